// File: doc/BRIEF.md
# Saturating Lane Narrowing Unit

This unit takes two 64-bit packed operands and narrows their lanes into one 64-bit packed result. Each wide lane is clamped to the range of the narrower lane, not truncated. It is meant for a media datapath. The execute stage presents a destination operand, a source operand and an operation select together with a valid strobe. One clock later the unit returns the narrowed result for write-back into the destination.

Three narrowing modes are provided:

- Signed doubleword to word: each 32-bit lane becomes a 16-bit lane.
- Signed word to byte: each 16-bit lane becomes an 8-bit lane.
- Unsigned word to byte: each 16-bit lane becomes an 8-bit lane, clamped to 0..255.

In every mode the input lanes are read as two's-complement numbers. The narrowed lanes from the destination operand fill the lower half of the result. The narrowed lanes from the source operand fill the upper half. Lane order is kept in both halves.

A new operation can be accepted on every clock.

Top module: `sat_pack_unit`

## Requirements
- R1: While rst_n is low at a rising edge, out_valid becomes 0 and out_result becomes all zeros.
- R2: With op_sel = 2'b00, each 32-bit input lane is clamped to a signed 16-bit word. Values above 32767 give 16'h7FFF, values below -32768 give 16'h8000, and other values pass through unchanged.
- R3: With op_sel = 2'b01, each 16-bit input lane is clamped to a signed byte. Values above 127 give 8'h7F, values below -128 give 8'h80, and other values pass through unchanged.
- R4: With op_sel = 2'b10, each 16-bit input lane, read as signed, is clamped to an unsigned byte. Negative values give 8'h00, values above 255 give 8'hFF, and values 0..255 pass through unchanged.
- R5: The result lanes are placed in a fixed order.
    - The lower half of out_result holds the narrowed destination lanes: lane i of dst_opnd goes to result lane i.
    - The upper half holds the narrowed source lanes: lane i of src_opnd goes to result lane i + (number of lanes per operand).
- R6: An operation with in_valid high and a legal op_sel at rising edge k appears on out_result, with out_valid high, after edge k. Back-to-back operations on consecutive clocks each produce their own result on consecutive cycles.
- R7: A rising edge with in_valid low leaves out_result unchanged and drives out_valid to 0.
- R8: op_sel = 2'b11 is reserved. With in_valid high it is ignored: out_result keeps its value and out_valid goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | Mode: 00 signed dword to word, 01 signed word to byte, 10 unsigned word to byte, 11 reserved |
| dst_opnd | input | 64 | Destination operand; supplies the lower result half |
| src_opnd | input | 64 | Source operand; supplies the upper result half |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 64 | Registered narrowed result |

## Verification
The assertions assume that op_sel and both operands carry meaningful values whenever in_valid is high. They also assume that a reserved op_sel may arrive with in_valid high and must then be ignored.

The bench changes all inputs only on the falling clock edge, so every rising edge samples a stable set of inputs. The stimulus covers the following:

- Random operands in every legal mode.
- Lane values placed exactly on each clamp threshold and one step beyond it.
- Idle cycles and reserved-code cycles inserted between valid operations, to exercise the hold behaviour.

// File: rtl/sat_pack_pkg.sv
// Package: shared operation codes for the saturating narrowing unit.
// Assumes a 2-bit select; code 2'b11 is reserved and never produces a result.
package sat_pack_pkg;

    typedef enum logic [1:0] {
        PK_SDW = 2'b00,
        PK_SWB = 2'b01,
        PK_UWB = 2'b10,
        PK_RSV = 2'b11
    } pack_op_e;

    // True for the three codes that produce a result.
    function automatic logic op_is_legal(input logic [1:0] op);
        return op != PK_RSV;
    endfunction

endpackage

// File: rtl/sat_lane_clamp.sv
// Module: clamps one two's-complement lane of IN_W bits into OUT_W bits.
// In signed mode the output range is [-2^(OUT_W-1), 2^(OUT_W-1)-1].
// In unsigned mode the output range is [0, 2^OUT_W-1].
// Assumes IN_W > OUT_W; the input is always read as signed.
module sat_lane_clamp #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  lane_in,
    input  logic             to_unsigned,
    output logic [OUT_W-1:0] lane_out
);

    localparam int EXT_W = IN_W - OUT_W;

    localparam logic signed [IN_W-1:0] SMAX = {{(EXT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] SMIN = {{(EXT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};
    localparam logic signed [IN_W-1:0] UMAX = {{EXT_W{1'b0}}, {OUT_W{1'b1}}};

    logic signed [IN_W-1:0] val;
    assign val = lane_in;

    // Select between the clamp limits and the low bits of the lane.
    always_comb begin
        if (to_unsigned) begin
            if (val < 0)
                lane_out = '0;
            else if (val > UMAX)
                lane_out = '1;
            else
                lane_out = lane_in[OUT_W-1:0];
        end else begin
            if (val > SMAX)
                lane_out = {1'b0, {(OUT_W-1){1'b1}}};
            else if (val < SMIN)
                lane_out = {1'b1, {(OUT_W-1){1'b0}}};
            else
                lane_out = lane_in[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/sat_pack_stage.sv
// Module: narrows every IN_W lane of two DATA_W operands into one DATA_W result.
// Destination lanes fill the low half and source lanes the high half, each in order.
// Assumes DATA_W is a multiple of IN_W and that IN_W = 2*OUT_W.
module sat_pack_stage #(
    parameter int DATA_W = 64,
    parameter int IN_W   = 16,
    parameter int OUT_W  = 8
) (
    input  logic [DATA_W-1:0] dst_opnd,
    input  logic [DATA_W-1:0] src_opnd,
    input  logic              to_unsigned,
    output logic [DATA_W-1:0] packed_out
);

    localparam int LANES_PER_OP = DATA_W / IN_W;
    localparam int LANES_TOTAL  = 2 * LANES_PER_OP;

    logic [2*DATA_W-1:0] joined;
    assign joined = {src_opnd, dst_opnd};

    // One clamp per output lane; lane k reads input lane k of the joined pair.
    for (genvar k = 0; k < LANES_TOTAL; k++) begin : g_lane
        sat_lane_clamp #(
            .IN_W (IN_W),
            .OUT_W(OUT_W)
        ) u_clamp (
            .lane_in    (joined[k*IN_W +: IN_W]),
            .to_unsigned(to_unsigned),
            .lane_out   (packed_out[k*OUT_W +: OUT_W])
        );
    end

endmodule

// File: rtl/sat_pack_unit.sv
// Module: top of the saturating narrowing unit.
// Builds both narrowing stages in parallel, selects one by op_sel and registers the result.
// Assumes a synchronous active-low reset.
// Assumes the inputs are stable around each rising edge at which in_valid is high.
module sat_pack_unit #(
    parameter int DATA_W = 64,
    parameter int WIDE_W = 32,
    parameter int MID_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] dst_opnd,
    input  logic [DATA_W-1:0] src_opnd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    import sat_pack_pkg::*;

    logic [DATA_W-1:0] dw_packed;
    logic [DATA_W-1:0] wb_packed;
    logic [DATA_W-1:0] sel_packed;
    logic              wb_unsigned;
    logic              accept;

    assign wb_unsigned = (op_sel == PK_UWB);
    assign accept      = in_valid && op_is_legal(op_sel);

    sat_pack_stage #(
        .DATA_W(DATA_W),
        .IN_W  (WIDE_W),
        .OUT_W (MID_W)
    ) u_dw (
        .dst_opnd   (dst_opnd),
        .src_opnd   (src_opnd),
        .to_unsigned(1'b0),
        .packed_out (dw_packed)
    );

    sat_pack_stage #(
        .DATA_W(DATA_W),
        .IN_W  (MID_W),
        .OUT_W (BYTE_W)
    ) u_wb (
        .dst_opnd   (dst_opnd),
        .src_opnd   (src_opnd),
        .to_unsigned(wb_unsigned),
        .packed_out (wb_packed)
    );

    // Pick the stage output that matches the requested mode.
    always_comb begin
        sel_packed = (op_sel == PK_SDW) ? dw_packed : wb_packed;
    end

    // Capture an accepted result; otherwise hold it and drop the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= accept;
            if (accept)
                out_result <= sel_packed;
        end
    end

endmodule

// File: rtl/sat_pack_checker.sv
// Module: property checker for sat_pack_unit, attached with bind below.
// Assumes the default lane widths: 32-bit wide lanes, 16-bit words and 8-bit bytes.
module sat_pack_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op_sel,
    input logic [DATA_W-1:0] dst_opnd,
    input logic [DATA_W-1:0] src_opnd,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel != 2'b11) |=> out_valid);  // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result)));  // R7

    AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b11) |=> (!out_valid && $stable(out_result)));  // R8

    AST_SDW_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b00 && $signed(dst_opnd[31:0]) > 32'sd32767)
        |=> out_result[15:0] == 16'h7FFF);  // R2

    AST_SWB_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b01 && $signed(dst_opnd[15:0]) < -16'sd128)
        |=> out_result[7:0] == 8'h80);  // R3

    AST_UWB_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b10 && src_opnd[63])
        |=> out_result[63:56] == 8'h00);  // R4

    AST_UWB_TOP_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'b10 && src_opnd[63:56] == 8'h00)
        |=> out_result[63:56] == src_opnd[55:48]);  // R5

endmodule

bind sat_pack_unit sat_pack_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .dst_opnd  (dst_opnd),
    .src_opnd  (src_opnd),
    .out_valid (out_valid),
    .out_result(out_result)
);

// File: tb/sat_pack_unit_test.sv
// Scoreboard bench for sat_pack_unit.
// The driver pushes expected results into a queue; the monitor pops and compares them.
module sat_pack_unit_test;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [63:0] dst_opnd = '0;
    logic [63:0] src_opnd = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int          checks = 0;
    int          errors = 0;
    sb_item_t    sbq[$];
    logic [63:0] last_exp = '0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    sat_pack_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_sel    (op_sel),
        .dst_opnd  (dst_opnd),
        .src_opnd  (src_opnd),
        .out_valid (out_valid),
        .out_result(out_result)
    );

    // Reference clamp of an integer into [lo, hi].
    function automatic int clampi(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // Expected result for one operation, built from the requirement text (R2, R3, R4, R5).
    function automatic logic [63:0] model(input logic [1:0] op, input logic [63:0] d,
                                          input logic [63:0] s);
        logic [127:0] j;
        logic [63:0]  r;
        j = {s, d};
        r = '0;
        if (op == 2'b00) begin
            for (int k = 0; k < 4; k++) begin
                int v;
                v = $signed(j[k*32 +: 32]);
                r[k*16 +: 16] = 16'(clampi(v, -32768, 32767));
            end
        end else begin
            for (int k = 0; k < 8; k++) begin
                int v;
                v = $signed(j[k*16 +: 16]);
                if (op == 2'b01)
                    r[k*8 +: 8] = 8'(clampi(v, -128, 127));
                else
                    r[k*8 +: 8] = 8'(clampi(v, 0, 255));
            end
        end
        return r;
    endfunction

    // Count one comparison and report a mismatch.
    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: present one operation and queue its expected result.
    task automatic send(input logic [1:0] op, input logic [63:0] d, input logic [63:0] s,
                        input string tag);
        sb_item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        op_sel   = op;
        dst_opnd = d;
        src_opnd = s;
        if (op != 2'b11) begin
            it.exp = model(op, d, s);
            it.tag = tag;
            sbq.push_back(it);
            last_exp = it.exp;
        end
    endtask

    // Drive one idle cycle.
    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        dst_opnd = 64'hDEAD_BEEF_0BAD_F00D;
    endtask

    // Check that the previous cycle left the result held and valid low, then go idle.
    task automatic check_hold(input string tag);
        @(negedge clk);
        check({tag, " valid"}, {63'd0, out_valid}, 64'd0);
        check({tag, " hold"}, out_result, last_exp);
        in_valid = 1'b0;
    endtask

    // Monitor: pop and compare on every valid output.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sbq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R6: unexpected valid, actual %h expected none", out_result);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                check(it.tag, out_result, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 valid", {63'd0, out_valid}, 64'd0);
        check("R1 result", out_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", out_result, 64'd0);

        // R2: signed dword boundaries, both halves.
        send(2'b00, {32'sd32768, 32'sd32767}, {-32'sd32769, -32'sd32768}, "R2 bounds");
        send(2'b00, {32'h7FFF_FFFF, 32'h8000_0000}, {32'd5, -32'sd5}, "R2 extremes");
        // R3: signed word boundaries.
        send(2'b01, {16'sd128, 16'sd127, -16'sd128, -16'sd129},
                    {16'h7FFF, 16'h8000, 16'd0, 16'hFFFF}, "R3 bounds");
        // R4: unsigned word boundaries.
        send(2'b10, {16'd256, 16'd255, 16'd0, 16'hFFFF},
                    {16'h8000, 16'd1, 16'd128, 16'h7FFF}, "R4 bounds");
        // R5: distinct in-range lanes expose order.
        send(2'b01, {16'd4, 16'd3, 16'd2, 16'd1}, {16'd8, 16'd7, 16'd6, 16'd5}, "R5 byte order");
        send(2'b00, {32'd2, 32'd1}, {32'd4, 32'd3}, "R5 word order");
        idle();
        // R7: idle holds the result.
        check_hold("R7");
        // R8: reserved op ignored.
        send(2'b11, 64'h0123_4567_89AB_CDEF, 64'h1111_2222_3333_4444, "R8");
        check_hold("R8");

        // R6: back-to-back random operations across all modes.
        for (int n = 0; n < 300; n++) begin
            logic [1:0] op;
            op = 2'($urandom_range(0, 2));
            send(op, {$urandom, $urandom}, {$urandom, $urandom}, "R6 random");
            if (n % 37 == 36) begin
                idle();
                check_hold("R7 gap");
            end
        end
        idle();
        @(negedge clk);
        checks++;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R6: pending results actual %0d expected 0", sbq.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule